// File: doc/BRIEF.md
# Logging Mission Start Sequencer

This block decides when a data-logging mission begins recording and which sample counters advance on each wake-up. A host issues a one-cycle start strobe together with a start delay in minutes and two mode bits: one asks for the mission to begin on a temperature alarm, and the other says that temperature logging is enabled. The sequencer counts the delay on a minute tick. After the delay it either logs at once or waits for an alarm, and it runs on the sample-interval tick from then on. That tick is built outside from the sample rate and the high-speed select bit.

It drives a mission-active flag and a memory-cleared flag. It also drives one-cycle strobes that capture the mission timestamp and write a log entry, and increment strobes for a mission sample counter and a device sample counter. Both counters are held inside the block and saturate. In alarm-triggered mode, every sample taken before the alarm advances only the device counter. The entry taken on the alarm sample is written without counting toward the mission. The timestamp is captured one sample period later, and from that sample on both counters advance together.

Top module: `mission_start_seq`

## Requirements
- R1: One cycle after `start_cmd` is accepted while `mission_active` is 0, `mission_active` reads 1, `mem_cleared` reads 0 and `mission_count` reads 0; the delay, `alarm_mode` and `temp_en` are captured on that cycle.
- R2: A `start_cmd` while `mission_active` is 1 is ignored: no strobe pulses, the delay is not restarted and `mission_count` is not cleared.
- R3: A `clear_cmd` while idle sets `mem_cleared` one cycle later; a `clear_cmd` while a mission is active leaves it at 0.
- R4: With programmed delay D, the delay ends on minute tick number max(D,1) after the start. Until then no strobe pulses and sample ticks are ignored.
- R5: In immediate mode (`alarm_mode`=0, or `temp_en`=0), the cycle after the minute tick that ends the delay pulses `ts_capture`, `log_entry`, `mission_inc` and `device_inc` together.
- R6: Once running, each `sample_tick` produces `log_entry`, `mission_inc` and `device_inc` one cycle later, without `ts_capture`. `temp_alarm` has no effect in this phase.
- R7: In alarm mode (`alarm_mode`=1 and `temp_en`=1), every sample tick after the delay pulses `device_inc` one cycle later. If `temp_alarm` is 1 on that tick, `log_entry` also pulses, and `mission_inc` does not.
- R8: After the alarm entry, the next `sample_tick` pulses all four strobes one cycle later, and behaviour from then on follows R6.
- R9: Each counter reads one higher in the cycle after its increment strobe, and holds at 2^CNT_W-1 instead of wrapping.
- R10: A synchronous `rst` returns the block to idle, with both flags at 0 and both counters at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_cmd | input | 1 | Start-mission strobe |
| clear_cmd | input | 1 | Memory-clear completion strobe |
| delay_min | input | DLY_W | Start delay in minutes |
| alarm_mode | input | 1 | Begin the mission on a temperature alarm |
| temp_en | input | 1 | Temperature logging enabled |
| minute_tick | input | 1 | One-cycle pulse per minute |
| sample_tick | input | 1 | One-cycle pulse per sample interval |
| temp_alarm | input | 1 | Temperature alarm for the current sample |
| mission_active | output | 1 | Mission in progress |
| mem_cleared | output | 1 | Log memory cleared |
| ts_capture | output | 1 | Capture the date and time into the mission timestamp |
| log_entry | output | 1 | Write one log entry |
| mission_inc | output | 1 | Mission sample counter increment |
| device_inc | output | 1 | Device sample counter increment |
| mission_count | output | CNT_W | Mission sample count |
| device_count | output | CNT_W | Device sample count |

## Verification
A wrong sequencer state shows up at the next tick. One example is leaving the delay one minute early or late: the four strobes then appear on the wrong minute tick, one cycle after that tick. A missed alarm shows up as well: the bench sees `log_entry` without `mission_inc` on the wrong sample, and a `ts_capture` that is missing or displaced on the sample after. A counter fault shows one cycle after its strobe, as a count that differs from the strobes already seen or that wraps past the saturation value.

// File: rtl/msseq_pkg.sv
package msseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DELAY,
      ST_ARMED,
      ST_LATCHED,
      ST_RUN
   } seq_state_t;

   typedef struct packed {
      logic ts;
      logic log;
      logic m_inc;
      logic d_inc;
   } seq_evt_t;

   localparam seq_evt_t EVT_NONE = '{ts: 1'b0, log: 1'b0, m_inc: 1'b0, d_inc: 1'b0};
endpackage

// File: rtl/msseq_delay.sv
module msseq_delay #(
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [DLY_W-1:0] load_val,
   input  logic             run,
   input  logic             minute_tick,
   output logic             expire
);
   localparam logic [DLY_W-1:0] ONE = {{(DLY_W-1){1'b0}}, 1'b1};

   generate
      if (DLY_W < 1) begin : g_bad_w
         $error("msseq_delay: DLY_W must be at least 1");
      end
   endgenerate

   logic [DLY_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst) begin
         remain <= '0;
      end else if (load) begin
         remain <= load_val;
      end else if (run && minute_tick && (remain > ONE)) begin
         remain <= remain - ONE;
      end
   end

   assign expire = run && minute_tick && (remain <= ONE);

   // R4: without a reload the remaining delay never grows
   p_delay_monotonic_r4: assert property (@(posedge clk) disable iff (rst)
      !load |=> (remain <= $past(remain)));
endmodule

// File: rtl/msseq_counter.sv
module msseq_counter #(
   parameter int W   = 24,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < 2) begin : g_bad_w
         $error("msseq_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] nxt;

   generate
      if (SAT) begin : g_sat
         assign nxt = (count == MAXV) ? count : count + ONE;

         // R9: a full counter stays full
         p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
            (count == MAXV && !clr) |=> (count == MAXV));
      end else begin : g_wrap
         assign nxt = count + ONE;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         count <= '0;
      end else if (inc) begin
         count <= nxt;
      end
   end

   // R9: without an increment or clear the count is held
   p_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!inc && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/msseq_fsm.sv
module msseq_fsm
   import msseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start_cmd,
   input  logic       clear_cmd,
   input  logic       alarm_mode,
   input  logic       temp_en,
   input  logic       sample_tick,
   input  logic       temp_alarm,
   input  logic       delay_expire,
   output seq_state_t state,
   output logic       load,
   output logic       mission_active,
   output logic       mem_cleared,
   output seq_evt_t   evt
);
   seq_state_t state_nxt;
   logic       alarm_sel;

   assign load = start_cmd && !mission_active;

   always_comb begin
      state_nxt = state;
      evt       = EVT_NONE;
      unique case (state)
         ST_IDLE: begin
            if (load) state_nxt = ST_DELAY;
         end
         ST_DELAY: begin
            if (delay_expire) begin
               if (alarm_sel) begin
                  state_nxt = ST_ARMED;
               end else begin
                  evt       = '{ts: 1'b1, log: 1'b1, m_inc: 1'b1, d_inc: 1'b1};
                  state_nxt = ST_RUN;
               end
            end
         end
         ST_ARMED: begin
            if (sample_tick) begin
               evt.d_inc = 1'b1;
               if (temp_alarm) begin
                  evt.log   = 1'b1;
                  state_nxt = ST_LATCHED;
               end
            end
         end
         ST_LATCHED: begin
            if (sample_tick) begin
               evt       = '{ts: 1'b1, log: 1'b1, m_inc: 1'b1, d_inc: 1'b1};
               state_nxt = ST_RUN;
            end
         end
         ST_RUN: begin
            if (sample_tick) begin
               evt = '{ts: 1'b0, log: 1'b1, m_inc: 1'b1, d_inc: 1'b1};
            end
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state          <= ST_IDLE;
         mission_active <= 1'b0;
         mem_cleared    <= 1'b0;
         alarm_sel      <= 1'b0;
      end else begin
         state <= state_nxt;
         if (load) begin
            mission_active <= 1'b1;
            mem_cleared    <= 1'b0;
            alarm_sel      <= alarm_mode && temp_en;
         end else if (clear_cmd && !mission_active) begin
            mem_cleared <= 1'b1;
         end
      end
   end

   // R1: an accepted start raises the mission flag and drops the cleared flag
   p_start_sets_r1: assert property (@(posedge clk) disable iff (rst)
      (start_cmd && !mission_active) |=> (mission_active && !mem_cleared));

   // R2: once active, a mission stays active until reset
   p_mission_holds_r2: assert property (@(posedge clk) disable iff (rst)
      mission_active |=> mission_active);

   // R3: the cleared flag never rises during a mission
   p_no_clear_in_mission_r3: assert property (@(posedge clk) disable iff (rst)
      (mission_active && !mem_cleared) |=> !mem_cleared);

   // R1: the sequencer leaves idle only with the mission flag set
   p_idle_vs_flag_r1: assert property (@(posedge clk) disable iff (rst)
      (state != ST_IDLE) |-> mission_active);
endmodule

// File: rtl/mission_start_seq.sv
module mission_start_seq
   import msseq_pkg::*;
#(
   parameter int DLY_W   = 16,
   parameter int CNT_W   = 24,
   parameter bit CNT_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start_cmd,
   input  logic             clear_cmd,
   input  logic [DLY_W-1:0] delay_min,
   input  logic             alarm_mode,
   input  logic             temp_en,
   input  logic             minute_tick,
   input  logic             sample_tick,
   input  logic             temp_alarm,
   output logic             mission_active,
   output logic             mem_cleared,
   output logic             ts_capture,
   output logic             log_entry,
   output logic             mission_inc,
   output logic             device_inc,
   output logic [CNT_W-1:0] mission_count,
   output logic [CNT_W-1:0] device_count
);
   generate
      if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
         $error("mission_start_seq: DLY_W out of range");
      end
      if (CNT_W < 2 || CNT_W > 48) begin : g_bad_cnt
         $error("mission_start_seq: CNT_W out of range");
      end
   endgenerate

   seq_state_t st;
   seq_evt_t   evt;
   logic       load;
   logic       expire;
   logic       in_delay;

   assign in_delay = (st == ST_DELAY);

   msseq_delay #(.DLY_W(DLY_W)) u_delay (
      .clk         (clk),
      .rst         (rst),
      .load        (load),
      .load_val    (delay_min),
      .run         (in_delay),
      .minute_tick (minute_tick),
      .expire      (expire)
   );

   msseq_fsm u_fsm (
      .clk            (clk),
      .rst            (rst),
      .start_cmd      (start_cmd),
      .clear_cmd      (clear_cmd),
      .alarm_mode     (alarm_mode),
      .temp_en        (temp_en),
      .sample_tick    (sample_tick),
      .temp_alarm     (temp_alarm),
      .delay_expire   (expire),
      .state          (st),
      .load           (load),
      .mission_active (mission_active),
      .mem_cleared    (mem_cleared),
      .evt            (evt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ts_capture  <= 1'b0;
         log_entry   <= 1'b0;
         mission_inc <= 1'b0;
         device_inc  <= 1'b0;
      end else begin
         ts_capture  <= evt.ts;
         log_entry   <= evt.log;
         mission_inc <= evt.m_inc;
         device_inc  <= evt.d_inc;
      end
   end

   msseq_counter #(.W(CNT_W), .SAT(CNT_SAT)) u_mcnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (load),
      .inc   (mission_inc),
      .count (mission_count)
   );

   msseq_counter #(.W(CNT_W), .SAT(CNT_SAT)) u_dcnt (
      .clk   (clk),
      .rst   (rst),
      .clr   (1'b0),
      .inc   (device_inc),
      .count (device_count)
   );

   // R8: a timestamp capture always comes with a log entry
   p_ts_with_log_r8: assert property (@(posedge clk) disable iff (rst)
      ts_capture |-> (log_entry && mission_inc));

   // R7: the mission counter never advances alone
   p_mission_implies_device_r7: assert property (@(posedge clk) disable iff (rst)
      mission_inc |-> device_inc);

   // R4: nothing is strobed while the delay is still running
   p_quiet_in_delay_r4: assert property (@(posedge clk) disable iff (rst)
      (in_delay && !expire) |=> !(log_entry || device_inc || ts_capture));

   // R6: every strobe answers a tick from the cycle before
   p_strobe_needs_tick_r6: assert property (@(posedge clk) disable iff (rst)
      device_inc |-> $past(sample_tick || minute_tick));
endmodule

// File: tb/mission_start_seq_tb.sv
module mission_start_seq_tb;
   localparam int DW = 4;
   localparam int CW = 4;
   localparam int MAXC = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst, start_cmd, clear_cmd, alarm_mode, temp_en;
   logic minute_tick, sample_tick, temp_alarm;
   logic [DW-1:0] delay_min;
   logic mission_active, mem_cleared, ts_capture, log_entry, mission_inc, device_inc;
   logic [CW-1:0] mission_count, device_count;

   int n_tests = 0;
   int n_fail  = 0;
   int exp_m   = 0;
   int exp_d   = 0;
   int cyc     = 0;

   always #5 clk = ~clk;

   mission_start_seq #(.DLY_W(DW), .CNT_W(CW), .CNT_SAT(1'b1)) u_dut (
      .clk(clk), .rst(rst), .start_cmd(start_cmd), .clear_cmd(clear_cmd),
      .delay_min(delay_min), .alarm_mode(alarm_mode), .temp_en(temp_en),
      .minute_tick(minute_tick), .sample_tick(sample_tick), .temp_alarm(temp_alarm),
      .mission_active(mission_active), .mem_cleared(mem_cleared),
      .ts_capture(ts_capture), .log_entry(log_entry), .mission_inc(mission_inc),
      .device_inc(device_inc), .mission_count(mission_count), .device_count(device_count)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests = n_tests + 1;
      if (act != exp) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1; start_cmd = 0; clear_cmd = 0; alarm_mode = 0; temp_en = 0;
      minute_tick = 0; sample_tick = 0; temp_alarm = 0; delay_min = '0;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      exp_m = 0; exp_d = 0;
      chk("R10 mission_active", mission_active, 0);
      chk("R10 mem_cleared", mem_cleared, 0);
      chk("R10 mission_count", mission_count, 0);
      chk("R10 device_count", device_count, 0);
   endtask

   // one-cycle stimulus, check strobes the next cycle and counts one cycle later
   task automatic pulse(input logic s, input logic m, input logic a, input logic st,
                        input logic cl, input logic ets, input logic elog,
                        input logic emi, input logic edi, input string req);
      sample_tick = s; minute_tick = m; temp_alarm = a; start_cmd = st; clear_cmd = cl;
      @(negedge clk);
      sample_tick = 0; minute_tick = 0; temp_alarm = 0; start_cmd = 0; clear_cmd = 0;
      chk({req, " ts_capture"}, ts_capture, ets);
      chk({req, " log_entry"}, log_entry, elog);
      chk({req, " mission_inc"}, mission_inc, emi);
      chk({req, " device_inc"}, device_inc, edi);
      if (emi && exp_m < MAXC) exp_m = exp_m + 1;
      if (edi && exp_d < MAXC) exp_d = exp_d + 1;
      @(negedge clk);
      chk({req, " R9 mission_count"}, mission_count, exp_m);
      chk({req, " R9 device_count"}, device_count, exp_d);
   endtask

   task automatic run_case(input logic am, input logic te, input int d, input int a);
      int last;
      do_reset();
      pulse(0, 0, 0, 0, 1, 0, 0, 0, 0, "R3 idle clear");
      chk("R3 mem_cleared set", mem_cleared, 1);
      delay_min = d[DW-1:0]; alarm_mode = am; temp_en = te;
      pulse(0, 0, 0, 1, 0, 0, 0, 0, 0, "R1 start");
      alarm_mode = 0; temp_en = 0; delay_min = '1;
      chk("R1 mission_active", mission_active, 1);
      chk("R1 mem_cleared", mem_cleared, 0);
      pulse(1, 0, 1, 0, 0, 0, 0, 0, 0, "R4 sample during delay");
      last = (d < 1) ? 1 : d;
      for (int k = 1; k <= last; k++) begin
         if (k == last && !(am && te))
            pulse(0, 1, 0, 0, 0, 1, 1, 1, 1, "R5 delay end entry");
         else
            pulse(0, 1, 0, 0, 0, 0, 0, 0, 0, "R4 delay minute");
      end
      if (am && te) begin
         pulse(0, 1, 0, 0, 0, 0, 0, 0, 0, "R7 minute after delay");
         for (int i = 0; i <= a; i++) begin
            if (i == a) pulse(1, 0, 1, 0, 0, 0, 1, 0, 1, "R7 alarm entry");
            else        pulse(1, 0, 0, 0, 0, 0, 0, 0, 1, "R7 pre-alarm sample");
         end
         pulse(0, 1, 0, 0, 0, 0, 0, 0, 0, "R8 minute ignored");
         pulse(1, 0, 0, 0, 0, 1, 1, 1, 1, "R8 timestamp sample");
      end
      pulse(1, 0, 1, 0, 0, 0, 1, 1, 1, "R6 running sample");
      pulse(0, 1, 0, 0, 0, 0, 0, 0, 0, "R6 minute ignored");
      delay_min = '0;
      pulse(0, 0, 0, 1, 0, 0, 0, 0, 0, "R2 restart ignored");
      pulse(1, 0, 0, 0, 0, 0, 1, 1, 1, "R2 still running");
      pulse(0, 0, 0, 0, 1, 0, 0, 0, 0, "R3 clear in mission");
      chk("R3 mem_cleared stays 0", mem_cleared, 0);
   endtask

   initial begin
      do_reset();
      for (int d = 0; d <= 3; d++) begin
         run_case(1'b0, 1'b0, d, 0);
         run_case(1'b1, 1'b0, d, 0);
         for (int a = 0; a <= 2; a++) run_case(1'b1, 1'b1, d, a);
      end
      // R9 saturation: long immediate mission
      run_case(1'b0, 1'b1, 0, 0);
      for (int i = 0; i < 20; i++) pulse(1, 0, 0, 0, 0, 0, 1, 1, 1, "R9 saturation run");
      chk("R9 saturated mission", mission_count, MAXC);
      chk("R9 saturated device", device_count, MAXC);
      // R10 reset in mid-mission
      do_reset();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule